// File: doc/BRIEF.md
# Receive Address Filter with Loadable Address Table

This block decides, for every incoming Ethernet frame, whether the receiver keeps it. The destination address arrives one byte per cycle, first byte first, and the frame length (FCS excluded) arrives on its own strobe. One clock after both are complete the block gives a single-cycle verdict: accept or reject, plus a type tag that marks a frame as multicast or broadcast. The checks follow a fixed priority. The runt test comes first, then promiscuous unicast, then all-multicast, then broadcast, and last the exact-match lookup in a 16-entry table of 6-byte addresses gated by a 16-bit enable mask.

The table is filled by a load command. A small sequencer walks a list of four-word descriptors through a memory read port that has any latency. Words 1 to 3 of each descriptor carry two address bytes each, low byte first. The sequencer fills entries 0, 1, 2 and onward. Word 0 of the descriptor after the last one becomes the enable mask. Descriptors pack their words in 16-bit slots, or in 32-bit slots when wide mode is selected. While the device-level reset bit is set, software can read any table entry back as three 16-bit words.

The loader states are LD_IDLE, LD_ENT_REQ, LD_ENT_WAIT, LD_MASK_REQ and LD_MASK_WAIT, with these transitions:
- LD_IDLE goes to LD_ENT_REQ on a start with a nonzero count, or to LD_MASK_REQ on a start with a zero count.
- LD_ENT_REQ goes to LD_ENT_WAIT after issuing a read.
- LD_ENT_WAIT returns to LD_ENT_REQ when a response arrives and more words remain. It goes to LD_MASK_REQ when the response completes word 3 of the last entry.
- LD_MASK_REQ goes to LD_MASK_WAIT after issuing a read.
- LD_MASK_WAIT goes to LD_IDLE when the mask response arrives.

Top module: `rx_addr_filter`

## Requirements
- R1: A frame whose length is below 60 is accepted only when `ctl_runt_ok` is 1, always with tag 0. This test overrides every other test, including broadcast.
- R2: When R1 does not apply, `ctl_promisc` is 1 and bit 0 of destination byte 0 is 0, the frame is accepted with tag 0. With only `ctl_promisc` set, a destination with that bit at 1 is not accepted by this test.
- R3: When R1 and R2 do not apply, `ctl_all_mcast` is 1 and bit 0 of destination byte 0 is 1, the frame is accepted with tag 1 (multicast). This includes the all-ones destination, even when `ctl_bcast` is also 1.
- R4: When R1 to R3 do not apply, `ctl_bcast` is 1 and all six destination bytes are 8'hFF, the frame is accepted with tag 2 (broadcast).
- R5: Otherwise the frame is accepted with tag 0 exactly when its six bytes equal a table entry whose bit is set in the enable mask, and rejected otherwise. A match on a disabled entry rejects.
- R6: `decision_valid` is high for exactly one cycle per frame. It rises on the clock edge after the edge that registered both the sixth destination byte and the length. `frame_start` re-arms the block.
- R7: A load of N entries writes entries 0 to N-1 in order. Entry k takes words 1, 2 and 3 of descriptor k. Descriptor k starts at `desc_base` + k*8 (or k*16 in wide mode), and word w sits at +2w (or +4w). Each word supplies bytes 2(w-1) (its low byte) and 2(w-1)+1 (its high byte). Only one read is outstanding at a time.
- R8: After the entries, word 0 of descriptor N is loaded as the enable mask, bit i enabling entry i. Then `load_busy` falls and `load_done` rises in the same cycle. A count of 0 loads only the mask. `load_done` is cleared by the next start.
- R9: With `reset_mode` at 1, `rb_data` shows entry `rb_entry`, where `rb_sel` = s gives byte 2s+1 in the high half and byte 2s in the low half. With `reset_mode` at 0, or `rb_sel` = 3, `rb_data` is 0.
- R10: After reset no verdict is pending, the loader is idle with `load_done` at 0, every table entry is 0, and the enable mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | Marks a new frame; clears collected bytes |
| dst_valid | input | 1 | Destination byte strobe |
| dst_byte | input | 8 | Destination byte, first byte first |
| len_valid | input | 1 | Length strobe |
| frame_len | input | 16 | Frame length in bytes, FCS excluded |
| ctl_runt_ok | input | 1 | Accept short frames |
| ctl_promisc | input | 1 | Accept every unicast destination |
| ctl_all_mcast | input | 1 | Accept every group destination |
| ctl_bcast | input | 1 | Accept the all-ones destination |
| decision_valid | output | 1 | One-cycle verdict strobe |
| decision_accept | output | 1 | Frame kept |
| decision_tag | output | 2 | 0 none, 1 multicast, 2 broadcast |
| load_start | input | 1 | Start a table load |
| load_count | input | 5 | Entries to load |
| desc_base | input | 16 | Byte address of the first descriptor |
| wide_mode | input | 1 | Descriptor words in 32-bit slots |
| load_busy | output | 1 | Load command in progress |
| load_done | output | 1 | Sticky load-complete status |
| mem_rd_en | output | 1 | Memory read request pulse |
| mem_addr | output | 16 | Byte address of the read |
| mem_rd_valid | input | 1 | Read response strobe |
| mem_rd_data | input | 16 | Read response data |
| reset_mode | input | 1 | Device reset bit; enables readback |
| rb_entry | input | 4 | Readback entry pointer |
| rb_sel | input | 2 | Readback word select |
| rb_data | output | 16 | Readback word |

## Verification
The hardest situation to reach is a verdict that depends on table contents laid out in wide mode. The only path to it is a full load sequence through a memory that answers two cycles late, with descriptors whose unused half-slots hold junk. The bench builds that memory image, loads two narrow entries, and then reloads entry 0 in wide mode so that any wrong stride picks up junk. Readback in reset mode and frames matched against enabled and disabled entries then expose the result. A final load with a zero count swaps in an empty mask, which must turn a previous match into a rejection.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [1:0] {
        TAG_NONE  = 2'd0,
        TAG_MCAST = 2'd1,
        TAG_BCAST = 2'd2
    } frame_tag_e;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_ENT_REQ,
        LD_ENT_WAIT,
        LD_MASK_REQ,
        LD_MASK_WAIT
    } load_state_e;
endpackage

// File: rtl/cam_loader.sv
module cam_loader
    import rxf_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int CNT_W = 5,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_start,
    input  logic [CNT_W-1:0] load_count,
    input  logic [AW-1:0]    desc_base,
    input  logic             wide_mode,
    output logic             load_busy,
    output logic             load_done,
    output logic             mem_rd_en,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rd_valid,
    input  logic [DW-1:0]    mem_rd_data,
    output logic             cam_we,
    output logic [IDX_W-1:0] cam_idx,
    output logic [1:0]       cam_word,
    output logic [DW-1:0]    cam_data,
    output logic             mask_we
);
    localparam logic [AW-1:0] DESC_NARROW = AW'(8);

    load_state_e      state, nxt;
    logic [AW-1:0]    ptr;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] entry;
    logic [1:0]       word;
    logic             wide_q;
    logic [1:0]       word_sel;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            LD_IDLE:      if (load_start)
                              nxt = (load_count == '0) ? LD_MASK_REQ : LD_ENT_REQ;
            LD_ENT_REQ:   nxt = LD_ENT_WAIT;
            LD_ENT_WAIT:  if (mem_rd_valid)
                              nxt = (word == 2'd3 && cnt == CNT_W'(1)) ? LD_MASK_REQ : LD_ENT_REQ;
            LD_MASK_REQ:  nxt = LD_MASK_WAIT;
            LD_MASK_WAIT: if (mem_rd_valid) nxt = LD_IDLE;
            default:      nxt = LD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        word_sel  = (state == LD_MASK_REQ) ? 2'd0 : word;
        mem_rd_en = (state == LD_ENT_REQ) || (state == LD_MASK_REQ);
        mem_addr  = ptr + (AW'(word_sel) << (wide_q ? 2 : 1));
        cam_we    = (state == LD_ENT_WAIT) && mem_rd_valid;
        cam_idx   = entry;
        cam_word  = word - 2'd1;
        cam_data  = mem_rd_data;
        mask_we   = (state == LD_MASK_WAIT) && mem_rd_valid;
        load_busy = (state != LD_IDLE);
    end

    // walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            cnt       <= '0;
            entry     <= '0;
            word      <= 2'd1;
            wide_q    <= 1'b0;
            load_done <= 1'b0;
        end else begin
            if (state == LD_IDLE && load_start) begin
                ptr       <= desc_base;
                cnt       <= load_count;
                entry     <= '0;
                word      <= 2'd1;
                wide_q    <= wide_mode;
                load_done <= 1'b0;
            end
            if (state == LD_ENT_WAIT && mem_rd_valid) begin
                if (word == 2'd3) begin
                    word  <= 2'd1;
                    entry <= entry + 1'b1;
                    cnt   <= cnt - 1'b1;
                    ptr   <= ptr + (DESC_NARROW << wide_q);
                end else begin
                    word <= word + 2'd1;
                end
            end
            if (state == LD_MASK_WAIT && mem_rd_valid) load_done <= 1'b1;
        end
    end

    assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);
    assert_done_with_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_busy) |-> load_done);
endmodule

// File: rtl/cam_store.sv
module cam_store #(
    parameter int NUM_ENT = 16,
    parameter int IDX_W   = 4,
    parameter int DW      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cam_we,
    input  logic [IDX_W-1:0] cam_idx,
    input  logic [1:0]       cam_word,
    input  logic [DW-1:0]    cam_data,
    input  logic             mask_we,
    input  logic [47:0]      dst_addr,
    output logic             cam_hit,
    input  logic             reset_mode,
    input  logic [IDX_W-1:0] rb_entry,
    input  logic [1:0]       rb_sel,
    output logic [DW-1:0]    rb_data
);
    logic [47:0]        ent [NUM_ENT];
    logic [NUM_ENT-1:0] en_mask;
    logic [NUM_ENT-1:0] hits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENT; i++) ent[i] <= '0;
            en_mask <= '0;
        end else begin
            if (cam_we) ent[cam_idx][{cam_word, 4'b0000} +: 16] <= cam_data;
            if (mask_we) en_mask <= cam_data[NUM_ENT-1:0];
        end
    end

    for (genvar gi = 0; gi < NUM_ENT; gi++) begin : g_match
        assign hits[gi] = en_mask[gi] && (ent[gi] == dst_addr);
    end

    assign cam_hit = |hits;

    always_comb begin
        rb_data = '0;
        if (reset_mode && rb_sel != 2'd3)
            rb_data = ent[rb_entry][{rb_sel, 4'b0000} +: 16];
    end

    assert_word_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cam_we |-> cam_word != 2'd3);
endmodule

// File: rtl/frame_filter.sv
module frame_filter
    import rxf_pkg::*;
#(
    parameter int LW      = 16,
    parameter int MIN_LEN = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          dst_valid,
    input  logic [7:0]    dst_byte,
    input  logic          len_valid,
    input  logic [LW-1:0] frame_len,
    input  logic          ctl_runt_ok,
    input  logic          ctl_promisc,
    input  logic          ctl_all_mcast,
    input  logic          ctl_bcast,
    input  logic          cam_hit,
    output logic [47:0]   dst_addr,
    output logic          decision_valid,
    output logic          decision_accept,
    output logic [1:0]    decision_tag
);
    localparam int BYTES = 6;

    logic [2:0]    bcnt;
    logic          have_len, decided, ready;
    logic [LW-1:0] len_q;
    logic          acc_c;
    frame_tag_e    tag_c;

    assign ready = (bcnt == 3'(BYTES)) && have_len && !decided;

    // priority ladder
    always_comb begin
        acc_c = 1'b0;
        tag_c = TAG_NONE;
        if (len_q < LW'(MIN_LEN)) begin
            acc_c = ctl_runt_ok;
        end else if (ctl_promisc && !dst_addr[0]) begin
            acc_c = 1'b1;
        end else if (ctl_all_mcast && dst_addr[0]) begin
            acc_c = 1'b1;
            tag_c = TAG_MCAST;
        end else if (ctl_bcast && (&dst_addr)) begin
            acc_c = 1'b1;
            tag_c = TAG_BCAST;
        end else begin
            acc_c = cam_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt            <= '0;
            have_len        <= 1'b0;
            decided         <= 1'b0;
            len_q           <= '0;
            dst_addr        <= '0;
            decision_valid  <= 1'b0;
            decision_accept <= 1'b0;
            decision_tag    <= TAG_NONE;
        end else if (frame_start) begin
            bcnt           <= '0;
            have_len       <= 1'b0;
            decided        <= 1'b0;
            decision_valid <= 1'b0;
        end else begin
            if (dst_valid && bcnt < 3'(BYTES)) begin
                dst_addr[{bcnt, 3'b000} +: 8] <= dst_byte;
                bcnt <= bcnt + 3'd1;
            end
            if (len_valid) begin
                len_q    <= frame_len;
                have_len <= 1'b1;
            end
            decision_valid <= ready;
            if (ready) begin
                decided         <= 1'b1;
                decision_accept <= acc_c;
                decision_tag    <= tag_c;
            end
        end
    end

    assert_runt_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !frame_start && len_q < LW'(MIN_LEN) && !ctl_runt_ok)
        |=> (decision_valid && !decision_accept));
    assert_promisc_unicast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !frame_start && len_q >= LW'(MIN_LEN) && ctl_promisc && !dst_addr[0])
        |=> (decision_valid && decision_accept && decision_tag == TAG_NONE));
    assert_tag_needs_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (decision_valid && decision_tag != TAG_NONE) |-> decision_accept);
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid |=> !decision_valid);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
    parameter int NUM_ENT = 16,
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int LW      = 16,
    parameter int CNT_W   = 5,
    parameter int MIN_LEN = 60
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_start,
    input  logic                       dst_valid,
    input  logic [7:0]                 dst_byte,
    input  logic                       len_valid,
    input  logic [LW-1:0]              frame_len,
    input  logic                       ctl_runt_ok,
    input  logic                       ctl_promisc,
    input  logic                       ctl_all_mcast,
    input  logic                       ctl_bcast,
    output logic                       decision_valid,
    output logic                       decision_accept,
    output logic [1:0]                 decision_tag,
    input  logic                       load_start,
    input  logic [CNT_W-1:0]           load_count,
    input  logic [AW-1:0]              desc_base,
    input  logic                       wide_mode,
    output logic                       load_busy,
    output logic                       load_done,
    output logic                       mem_rd_en,
    output logic [AW-1:0]              mem_addr,
    input  logic                       mem_rd_valid,
    input  logic [DW-1:0]              mem_rd_data,
    input  logic                       reset_mode,
    input  logic [$clog2(NUM_ENT)-1:0] rb_entry,
    input  logic [1:0]                 rb_sel,
    output logic [DW-1:0]              rb_data
);
    localparam int IDX_W = $clog2(NUM_ENT);

    logic             cam_we, mask_we, cam_hit;
    logic [IDX_W-1:0] cam_idx;
    logic [1:0]       cam_word;
    logic [DW-1:0]    cam_data;
    logic [47:0]      dst_addr;

    cam_loader #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_loader (
        .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_count(load_count),
        .desc_base(desc_base), .wide_mode(wide_mode), .load_busy(load_busy),
        .load_done(load_done), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .cam_we(cam_we),
        .cam_idx(cam_idx), .cam_word(cam_word), .cam_data(cam_data), .mask_we(mask_we)
    );

    cam_store #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .cam_we(cam_we), .cam_idx(cam_idx),
        .cam_word(cam_word), .cam_data(cam_data), .mask_we(mask_we),
        .dst_addr(dst_addr), .cam_hit(cam_hit), .reset_mode(reset_mode),
        .rb_entry(rb_entry), .rb_sel(rb_sel), .rb_data(rb_data)
    );

    frame_filter #(.LW(LW), .MIN_LEN(MIN_LEN)) u_filter (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dst_valid(dst_valid),
        .dst_byte(dst_byte), .len_valid(len_valid), .frame_len(frame_len),
        .ctl_runt_ok(ctl_runt_ok), .ctl_promisc(ctl_promisc),
        .ctl_all_mcast(ctl_all_mcast), .ctl_bcast(ctl_bcast), .cam_hit(cam_hit),
        .dst_addr(dst_addr), .decision_valid(decision_valid),
        .decision_accept(decision_accept), .decision_tag(decision_tag)
    );
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 0, dst_valid = 0, len_valid = 0;
    logic [7:0]  dst_byte = '0;
    logic [15:0] frame_len = '0;
    logic        ctl_runt_ok = 0, ctl_promisc = 0, ctl_all_mcast = 0, ctl_bcast = 0;
    logic        decision_valid, decision_accept;
    logic [1:0]  decision_tag;
    logic        load_start = 0, wide_mode = 0;
    logic [4:0]  load_count = '0;
    logic [15:0] desc_base = '0;
    logic        load_busy, load_done, mem_rd_en;
    logic [15:0] mem_addr;
    logic        mem_rd_valid = 0;
    logic [15:0] mem_rd_data = '0;
    logic        reset_mode = 0;
    logic [3:0]  rb_entry = '0;
    logic [1:0]  rb_sel = '0;
    logic [15:0] rb_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [47:0] ADDR_A = 48'h554433221102;
    localparam logic [47:0] ADDR_B = 48'hFFEEDDCCBBAA;
    localparam logic [47:0] ADDR_C = 48'h665544332266;
    localparam logic [47:0] ADDR_U = 48'h123456789A00;
    localparam logic [47:0] ADDR_M = 48'hFB00005E0001;
    localparam logic [47:0] ADDR_F = 48'hFFFFFFFFFFFF;

    always #5 clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .dst_valid(dst_valid),
        .dst_byte(dst_byte), .len_valid(len_valid), .frame_len(frame_len),
        .ctl_runt_ok(ctl_runt_ok), .ctl_promisc(ctl_promisc),
        .ctl_all_mcast(ctl_all_mcast), .ctl_bcast(ctl_bcast),
        .decision_valid(decision_valid), .decision_accept(decision_accept),
        .decision_tag(decision_tag), .load_start(load_start), .load_count(load_count),
        .desc_base(desc_base), .wide_mode(wide_mode), .load_busy(load_busy),
        .load_done(load_done), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .reset_mode(reset_mode), .rb_entry(rb_entry), .rb_sel(rb_sel), .rb_data(rb_data)
    );

    // memory model, two-cycle read latency
    logic [15:0] mem [0:127];
    logic        p1 = 0;
    logic [15:0] a1 = '0;
    always @(posedge clk) begin
        p1           <= mem_rd_en;
        a1           <= mem_addr;
        mem_rd_valid <= p1;
        mem_rd_data  <= mem[a1[7:1]];
    end

    task automatic chk(input bit ok, input string rq, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // scoreboard
    logic [2:0] exp_q[$];
    string      name_q[$];

    always @(negedge clk) begin
        if (rst_n && decision_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected verdict", 48'(decision_valid), 48'd0);
            end else begin
                logic [2:0] e;
                string n;
                e = exp_q.pop_front();
                n = name_q.pop_front();
                chk({decision_accept, decision_tag} == e, n,
                    48'({decision_accept, decision_tag}), 48'(e));
            end
        end
    end

    task automatic send_frame(input logic [47:0] d, input int len, input bit acc,
                              input logic [1:0] tag, input string rq);
        exp_q.push_back({acc, tag});
        name_q.push_back(rq);
        @(negedge clk) frame_start = 1;
        @(negedge clk) frame_start = 0;
        for (int i = 0; i < 6; i++) begin
            dst_valid = 1;
            dst_byte  = d[8*i +: 8];
            if (i == 5) begin
                len_valid = 1;
                frame_len = 16'(len);
            end
            @(negedge clk);
        end
        dst_valid = 0;
        len_valid = 0;
        chk(decision_valid == 1'b0, "R6 early", 48'(decision_valid), 48'd0);
        @(negedge clk);
        chk(decision_valid == 1'b1, "R6 timing", 48'(decision_valid), 48'd1);
        @(negedge clk);
        chk(decision_valid == 1'b0, "R6 single pulse", 48'(decision_valid), 48'd0);
    endtask

    task automatic do_load(input logic [15:0] base, input logic [4:0] n, input bit wide);
        @(negedge clk);
        desc_base  = base;
        load_count = n;
        wide_mode  = wide;
        load_start = 1;
        @(negedge clk) load_start = 0;
        chk(load_busy == 1'b1 && load_done == 1'b0, "R8 busy after start",
            48'({load_busy, load_done}), 48'b10);
        for (int t = 0; t < 200 && !load_done; t++) @(negedge clk);
        chk(load_done == 1'b1 && load_busy == 1'b0, "R8 done", 48'({load_busy, load_done}), 48'b01);
    endtask

    task automatic rb_entry_chk(input logic [3:0] e, input logic [47:0] exp, input string rq);
        logic [47:0] got;
        reset_mode = 1;
        rb_entry   = e;
        for (int s = 0; s < 3; s++) begin
            rb_sel = 2'(s);
            #1;
            got[16*s +: 16] = rb_data;
        end
        chk(got == exp, rq, got, exp);
        reset_mode = 0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 16'hDEAD;
        // narrow list at 0x10: A then B, mask 0x0001 at 0x20
        mem[8'h12 >> 1] = 16'h1102; mem[8'h14 >> 1] = 16'h3322; mem[8'h16 >> 1] = 16'h5544;
        mem[8'h1A >> 1] = 16'hBBAA; mem[8'h1C >> 1] = 16'hDDCC; mem[8'h1E >> 1] = 16'hFFEE;
        mem[8'h20 >> 1] = 16'h0001;
        // wide list at 0x40: C, mask 0x0003 at 0x50
        mem[8'h44 >> 1] = 16'h2266; mem[8'h48 >> 1] = 16'h4433; mem[8'h4C >> 1] = 16'h6655;
        mem[8'h50 >> 1] = 16'h0003;
        // empty list at 0x60, mask 0
        mem[8'h60 >> 1] = 16'h0000;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk(decision_valid == 0 && load_busy == 0 && load_done == 0, "R10 outputs",
            48'({decision_valid, load_busy, load_done}), 48'd0);
        rb_entry_chk(4'd0, 48'd0, "R10 table cleared");
        send_frame(ADDR_U, 64, 1'b0, 2'd0, "R10 empty mask rejects");

        do_load(16'h0010, 5'd2, 1'b0);
        rb_entry_chk(4'd0, ADDR_A, "R7 entry0 narrow");
        rb_entry_chk(4'd1, ADDR_B, "R7 entry1 narrow");
        reset_mode = 1; rb_entry = 4'd0; rb_sel = 2'd3; #1;
        chk(rb_data == 16'h0, "R9 sel3 zero", 48'(rb_data), 48'd0);
        reset_mode = 0; rb_sel = 2'd0; #1;
        chk(rb_data == 16'h0, "R9 no reset bit zero", 48'(rb_data), 48'd0);
        reset_mode = 1; rb_sel = 2'd1; #1;
        chk(rb_data == 16'h3322, "R9 word select", 48'(rb_data), 48'h3322);
        reset_mode = 0;

        send_frame(ADDR_A, 64, 1'b1, 2'd0, "R5 enabled match");
        send_frame(ADDR_B, 64, 1'b0, 2'd0, "R5 disabled entry");
        send_frame(ADDR_U, 64, 1'b0, 2'd0, "R5 no match");

        send_frame(ADDR_A, 59, 1'b0, 2'd0, "R1 runt rejected");
        send_frame(ADDR_A, 60, 1'b1, 2'd0, "R1 length 60 not runt");
        ctl_runt_ok = 1;
        send_frame(ADDR_U, 20, 1'b1, 2'd0, "R1 runt accepted");
        ctl_runt_ok = 0; ctl_bcast = 1;
        send_frame(ADDR_F, 30, 1'b0, 2'd0, "R1 runt before broadcast");

        ctl_bcast = 0; ctl_promisc = 1;
        send_frame(ADDR_U, 64, 1'b1, 2'd0, "R2 promisc unicast");
        send_frame(ADDR_M, 64, 1'b0, 2'd0, "R2 promisc ignores group");
        ctl_promisc = 0; ctl_all_mcast = 1;
        send_frame(ADDR_M, 64, 1'b1, 2'd1, "R3 all multicast");
        ctl_bcast = 1;
        send_frame(ADDR_F, 64, 1'b1, 2'd1, "R3 precedes broadcast");
        ctl_all_mcast = 0;
        send_frame(ADDR_F, 64, 1'b1, 2'd2, "R4 broadcast");
        ctl_bcast = 0;
        send_frame(ADDR_F, 64, 1'b0, 2'd0, "R4 broadcast disabled");

        do_load(16'h0040, 5'd1, 1'b1);
        rb_entry_chk(4'd0, ADDR_C, "R7 entry0 wide");
        rb_entry_chk(4'd1, ADDR_B, "R7 entry1 kept");
        send_frame(ADDR_C, 64, 1'b1, 2'd0, "R5 wide entry match");
        send_frame(ADDR_B, 64, 1'b1, 2'd0, "R8 mask enables entry1");
        send_frame(ADDR_A, 64, 1'b0, 2'd0, "R7 old entry replaced");

        do_load(16'h0060, 5'd0, 1'b0);
        rb_entry_chk(4'd0, ADDR_C, "R8 zero count keeps entries");
        send_frame(ADDR_C, 64, 1'b0, 2'd0, "R8 zero count mask");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 verdict count", 48'(exp_q.size()), 48'd0);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule